// File: doc/BRIEF.md
# Dual-Channel Coherent Single-Bin DFT Accumulator

This block measures the amplitude and starting phase of two sinusoids that are sampled together: the voltage driven onto a sensor and the current-sense signal that comes back. It correlates each record against a cosine and a sine reference at one integer DFT bin. It works only on that bin, so the record length does not have to be a power of two. The frequency, record length and sample rate must satisfy the coherent-sampling rule fs·Nc = f·N, which makes the bin index q = f·N/fs an integer.

The host pulses `start` with the record length N and the bin index q on the inputs. It then streams N sample pairs, marking each pair with a valid strobe. Both channels use the same reference value for every pair. Their bin sums can therefore be divided by each other to give the complex impedance at that frequency. A single-cycle `done` marks the end of the record. The host forms the ratio and steps through the frequency points of a sweep, commonly 401 of them.

The references come from a quarter-wave sine table. An index accumulator that counts modulo N addresses the table through a scaled lookup.

Top module: `sdft_dual_bin`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and all four sums are 0.
- R2: A `start` pulse latches N and q, zeroes all four sums and sets `busy` on the next edge. A sample pair presented in the same cycle as `start` is not accumulated.
- R3: A pair is accumulated only on an edge where `busy` and `smp_valid` are both 1. While idle, or while `smp_valid` is 0, the sums hold their value.
- R4: For the k-th accepted pair, the table address is a = floor(1024·m/N), where m starts at 0 and advances as m ← (m+q) mod N. The sine reference is round(32767·sin(2π·a/1024)), with halves rounded away from zero. The cosine reference is the sine reference at address (a+256) mod 1024.
- R5: For each channel with sample x, the real sum adds x·cos_ref and the imaginary sum subtracts x·sin_ref. Both channels use the same reference pair.
- R6: `done` is 1 for exactly one cycle. That cycle follows the edge that accepted the N-th pair, and `busy` falls on the same edge.
- R7: For a coherent input x = A·sin(2πqk/N+φ) with 0<q<N/2, the real sum is about 32767·(A·N/2)·sin φ and the imaginary sum is about −32767·(A·N/2)·cos φ.
- R8: With q = 0, the cosine reference is +32767 and the sine reference is 0 for every sample. The real sum is then 32767·Σx and the imaginary sum is 0.
- R9: The 44-bit signed sums cannot overflow for any N up to 65535 with full-scale 12-bit samples.
- R10: A record of length N = 1 completes after a single accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new record; latches rec_len and bin_idx |
| rec_len | input | 16 | Record length N, from 1 to 65535 |
| bin_idx | input | 16 | Bin index q, less than N |
| smp_valid | input | 1 | Sample pair present this cycle |
| exc_smp | input | 12 | Excitation channel sample, signed |
| rsp_smp | input | 12 | Response channel sample, signed |
| busy | output | 1 | Record in progress |
| done | output | 1 | One-cycle pulse at end of record |
| exc_re | output | 44 | Excitation real sum, signed |
| exc_im | output | 44 | Excitation imaginary sum, signed |
| rsp_re | output | 44 | Response real sum, signed |
| rsp_im | output | 44 | Response imaginary sum, signed |

## Verification
The bench covers these corner cases:

- **q = 0.** A design that swapped the cosine and sine quadrants would put a DC input into the imaginary sum.
- **q = N/2.** The sine reference must be zero at every sample. A wrong sign on quadrants 2 and 3 of the table would leave a residue there.
- **N = 1, and N = 401, a length that is not a power of two.** A phase accumulator that does not wrap at N would drift off the bin.
- **Gaps in the valid strobe, and samples presented while idle.** A design that ignored the valid qualifier would absorb these values.
- **Restart with a valid pair in the same cycle as `start`.** This catches a design that takes that pair or fails to clear the sums.
- **Full-scale input.** An accumulator that is too narrow would wrap.

// File: rtl/sdft_pkg.sv
// Package: widths shared by the single-bin DFT accumulator and its sub-blocks.
// Assumes the record-length width bounds N, so sums need SMP+REF+N bits.
package sdft_pkg;
    localparam int SDFT_SMP_W  = 12;  // signed sample width
    localparam int SDFT_REF_W  = 16;  // signed reference width
    localparam int SDFT_N_W    = 16;  // record length / bin index width
    localparam int SDFT_TBL_AW = 10;  // full-cycle table address width
    localparam int SDFT_NUM_CH = 2;   // excitation and response channels
endpackage

// File: rtl/sdft_phase_gen.sv
// Phase generator: index accumulator modulo N, scaled to a table address.
// Assumes step < len and len >= 1 while adv is asserted.
module sdft_phase_gen #(
    parameter int N_W    = 16,
    parameter int TBL_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [N_W-1:0]    len,
    input  logic [N_W-1:0]    step,
    output logic [TBL_AW-1:0] addr
);
    localparam int SC_W = N_W + TBL_AW;

    logic [N_W-1:0]  idx;
    logic [N_W:0]    sum;
    logic [N_W:0]    wrapped;
    logic [SC_W-1:0] scaled;
    logic [SC_W-1:0] quot;

    // next index candidates: plain advance and advance minus N
    assign sum     = {1'b0, idx} + {1'b0, step};
    assign wrapped = sum - {1'b0, len};

    // index register, cleared at the start of a record, advanced per accepted pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (adv)
            idx <= (sum >= {1'b0, len}) ? wrapped[N_W-1:0] : sum[N_W-1:0];
    end

    // scale the index by table size over N: addr = floor(idx * 2^TBL_AW / len)
    assign scaled = {idx, {TBL_AW{1'b0}}};
    always_comb begin
        if (len == '0)
            quot = '0;
        else
            quot = scaled / SC_W'(len);
    end
    assign addr = quot[TBL_AW-1:0];

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (idx < len)); // R4

endmodule

// File: rtl/sdft_sine_rom.sv
// Quarter-wave sine table with two read ports for the sine and cosine references.
// Entries are round(peak*sin) for the first quarter, computed at elaboration;
// the other quadrants are obtained by mirroring the address and negating the value.
module sdft_sine_rom #(
    parameter int REF_W  = 16,
    parameter int TBL_AW = 10
) (
    input  logic [TBL_AW-1:0]        addr_a,
    input  logic [TBL_AW-1:0]        addr_b,
    output logic signed [REF_W-1:0]  val_a,
    output logic signed [REF_W-1:0]  val_b
);
    localparam int  TBL_N = 2 ** TBL_AW;
    localparam int  QTR   = TBL_N / 4;
    localparam real PEAK  = real'(2 ** (REF_W - 1) - 1);
    localparam real TWOPI = 6.283185307179586;

    logic signed [REF_W-1:0] qtab [QTR+1];

    // one constant table entry per first-quadrant phase, endpoints included
    for (genvar gi = 0; gi <= QTR; gi++) begin : g_qtab
        localparam real ANG = TWOPI * real'(gi) / real'(TBL_N);
        localparam int  VAL = int'($floor(PEAK * $sin(ANG) + 0.5));
        assign qtab[gi] = REF_W'(VAL);
    end

    // map a full-cycle address onto the quarter table with mirroring and sign
    function automatic logic signed [REF_W-1:0] lookup(input logic [TBL_AW-1:0] a);
        logic [TBL_AW-2:0] off;
        off = {1'b0, a[TBL_AW-3:0]};
        if (a[TBL_AW-2])
            off = (TBL_AW-1)'(QTR) - off;
        lookup = a[TBL_AW-1] ? -qtab[off] : qtab[off];
    endfunction

    // both read ports are combinational
    always_comb begin
        val_a = lookup(addr_a);
        val_b = lookup(addr_b);
    end

endmodule

// File: rtl/sdft_bin_acc.sv
// One channel's complex bin accumulator: re += x*cos, im -= x*sin.
// Assumes the sum width covers the largest record, so no saturation is needed.
module sdft_bin_acc #(
    parameter int SMP_W = 12,
    parameter int REF_W = 16,
    parameter int ACC_W = 44
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [SMP_W-1:0] x,
    input  logic signed [REF_W-1:0] cos_ref,
    input  logic signed [REF_W-1:0] sin_ref,
    output logic signed [ACC_W-1:0] acc_re,
    output logic signed [ACC_W-1:0] acc_im
);
    localparam int PW = SMP_W + REF_W;

    logic signed [PW-1:0]    prod_c;
    logic signed [PW-1:0]    prod_s;
    logic signed [ACC_W-1:0] add_re;
    logic signed [ACC_W-1:0] add_im;
    logic signed [ACC_W-1:0] nxt_re;
    logic signed [ACC_W-1:0] nxt_im;

    // products and sign-extended increments for both bin components
    assign prod_c = PW'(x) * PW'(cos_ref);
    assign prod_s = PW'(x) * PW'(sin_ref);
    assign add_re = ACC_W'(prod_c);
    assign add_im = -ACC_W'(prod_s);
    assign nxt_re = acc_re + add_re;
    assign nxt_im = acc_im + add_im;

    // sum registers: cleared on a new record, updated per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (clr) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            acc_re <= nxt_re;
            acc_im <= nxt_im;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> !((acc_re[ACC_W-1] == add_re[ACC_W-1]) &&
                           (nxt_re[ACC_W-1] != acc_re[ACC_W-1]))); // R9
    AST_NO_OVERFLOW_IM: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> !((acc_im[ACC_W-1] == add_im[ACC_W-1]) &&
                           (nxt_im[ACC_W-1] != acc_im[ACC_W-1]))); // R9

endmodule

// File: rtl/sdft_dual_bin.sv
// Top: two-channel coherent single-bin DFT accumulator.
// A start pulse latches N and q; N valid sample pairs are correlated against
// a shared cosine/sine reference; done pulses once after the N-th pair.
// Assumes 1 <= N and q < N; samples offered while idle are dropped.
module sdft_dual_bin
    import sdft_pkg::*;
#(
    parameter  int SMP_W  = SDFT_SMP_W,
    parameter  int REF_W  = SDFT_REF_W,
    parameter  int N_W    = SDFT_N_W,
    parameter  int TBL_AW = SDFT_TBL_AW,
    localparam int ACC_W  = SMP_W + REF_W + N_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_W-1:0]          rec_len,
    input  logic [N_W-1:0]          bin_idx,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] exc_smp,
    input  logic signed [SMP_W-1:0] rsp_smp,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] exc_re,
    output logic signed [ACC_W-1:0] exc_im,
    output logic signed [ACC_W-1:0] rsp_re,
    output logic signed [ACC_W-1:0] rsp_im
);
    localparam int QTR = 2 ** (TBL_AW - 2);

    logic [N_W-1:0]          len_r;
    logic [N_W-1:0]          bin_r;
    logic [N_W-1:0]          cnt_r;
    logic                    take;
    logic [TBL_AW-1:0]       sin_addr;
    logic [TBL_AW-1:0]       cos_addr;
    logic signed [REF_W-1:0] sin_ref;
    logic signed [REF_W-1:0] cos_ref;
    logic signed [SMP_W-1:0] ch_x  [SDFT_NUM_CH];
    logic signed [ACC_W-1:0] ch_re [SDFT_NUM_CH];
    logic signed [ACC_W-1:0] ch_im [SDFT_NUM_CH];

    // a pair is consumed only while a record runs and no restart is requested
    assign take = busy && smp_valid && !start;

    // record control: latch parameters, count accepted pairs, pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_r <= '0;
            len_r <= '0;
            bin_r <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                cnt_r <= '0;
                len_r <= rec_len;
                bin_r <= bin_idx;
            end else if (take) begin
                cnt_r <= cnt_r + 1'b1;
                if (cnt_r == len_r - 1'b1) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    sdft_phase_gen #(.N_W(N_W), .TBL_AW(TBL_AW)) phase_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .adv  (take),
        .len  (len_r),
        .step (bin_r),
        .addr (sin_addr)
    );

    // cosine is the sine a quarter period later
    assign cos_addr = sin_addr + TBL_AW'(QTR);

    sdft_sine_rom #(.REF_W(REF_W), .TBL_AW(TBL_AW)) rom_i (
        .addr_a(sin_addr),
        .addr_b(cos_addr),
        .val_a (sin_ref),
        .val_b (cos_ref)
    );

    assign ch_x[0] = exc_smp;
    assign ch_x[1] = rsp_smp;

    // one accumulator per channel, all fed the same reference pair
    for (genvar gc = 0; gc < SDFT_NUM_CH; gc++) begin : g_ch
        sdft_bin_acc #(.SMP_W(SMP_W), .REF_W(REF_W), .ACC_W(ACC_W)) acc_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (start),
            .en     (take),
            .x      (ch_x[gc]),
            .cos_ref(cos_ref),
            .sin_ref(sin_ref),
            .acc_re (ch_re[gc]),
            .acc_im (ch_im[gc])
        );
    end

    assign exc_re = ch_re[0];
    assign exc_im = ch_im[0];
    assign rsp_re = ch_re[1];
    assign rsp_im = ch_im[1];

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done && exc_re == '0 && exc_im == '0 &&
                   rsp_re == '0 && rsp_im == '0)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(exc_re) && $stable(exc_im) &&
                               $stable(rsp_re) && $stable(rsp_im))); // R3
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !start) |=> ($stable(exc_re) && $stable(rsp_im))); // R3

endmodule

// File: tb/sdft_dual_bin_tb.sv
// Bench: behavioural per-cycle model of the bin sums, compared on every clock,
// plus directed record scenarios with closed-form expectations.
module sdft_dual_bin_tb_top;
    localparam int  SW = 12;
    localparam int  NW = 16;
    localparam int  AW = 44;
    localparam real PI = 3.141592653589793;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic smp_valid = 1'b0;
    logic [NW-1:0] rec_len = '0;
    logic [NW-1:0] bin_idx = '0;
    logic signed [SW-1:0] exc_smp = '0;
    logic signed [SW-1:0] rsp_smp = '0;
    logic busy, done;
    logic signed [AW-1:0] exc_re, exc_im, rsp_re, rsp_im;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;

    always #10 clk = ~clk;

    sdft_dual_bin dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rec_len(rec_len),
        .bin_idx(bin_idx), .smp_valid(smp_valid), .exc_smp(exc_smp),
        .rsp_smp(rsp_smp), .busy(busy), .done(done), .exc_re(exc_re),
        .exc_im(exc_im), .rsp_re(rsp_re), .rsp_im(rsp_im)
    );

    // ---------------- reference model ----------------
    bit m_busy = 0, m_done = 0;
    int m_len = 1, m_bin = 0, m_idx = 0, m_cnt = 0;
    longint m_er = 0, m_ei = 0, m_rr = 0, m_ri = 0, m_te = 0, m_tr = 0;

    function automatic longint ref_val(int a);
        real v;
        v = 32767.0 * $sin(2.0 * PI * real'(a) / 1024.0);
        if (v >= 0.0) return longint'($floor(v + 0.5));
        return -longint'($floor(-v + 0.5));
    endfunction

    function automatic longint labs(longint v);
        return (v < 0) ? -v : v;
    endfunction

    always @(posedge clk) begin : model
        int a;
        longint c, s, xe, xr;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_idx = 0; m_cnt = 0;
            m_er = 0; m_ei = 0; m_rr = 0; m_ri = 0; m_te = 0; m_tr = 0;
        end else begin
            m_done = 0;
            if (start) begin
                m_busy = 1; m_len = int'(rec_len); m_bin = int'(bin_idx);
                m_idx = 0; m_cnt = 0;
                m_er = 0; m_ei = 0; m_rr = 0; m_ri = 0; m_te = 0; m_tr = 0;
            end else if (m_busy && smp_valid) begin
                a  = (m_idx * 1024) / m_len;
                c  = ref_val((a + 256) % 1024);
                s  = ref_val(a);
                xe = longint'(exc_smp);
                xr = longint'(rsp_smp);
                m_er += xe * c; m_ei -= xe * s;
                m_rr += xr * c; m_ri -= xr * s;
                m_te += labs(xe); m_tr += labs(xr);
                m_idx = (m_idx + m_bin) % m_len;
                m_cnt++;
                if (m_cnt == m_len) begin
                    m_busy = 0; m_done = 1;
                end
            end
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(string req, string what, longint got, longint exp, longint tol);
        n_chk++;
        if (labs(got - exp) > tol) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d (tol %0d)", req, what, got, exp, tol);
        end
    endtask

    task automatic chk_real(string req, string what, longint got, real exp, real tol);
        n_chk++;
        if ((real'(got) - exp > tol) || (exp - real'(got) > tol)) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0.0f (tol %0.0f)", req, what, got, exp, tol);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // per-cycle comparison against the model; one reference LSB per sample allowed
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R5", "exc_re", exc_re, m_er, m_te);
            chk("R5", "exc_im", exc_im, m_ei, m_te);
            chk("R5", "rsp_re", rsp_re, m_rr, m_tr);
            chk("R5", "rsp_im", rsp_im, m_ri, m_tr);
            chk("R6", "done", longint'(done), longint'(m_done), 0);
            chk("R2", "busy", longint'(busy), longint'(m_busy), 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL R6 watchdog: got no completion expected done within limit");
            finish_up();
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic signed [SW-1:0] samp(real amp, real ph_deg, int k, int n, int q);
        real v;
        int r;
        v = amp * $sin(2.0 * PI * real'(q) * real'(k) / real'(n) + ph_deg * PI / 180.0);
        r = (v >= 0.0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return SW'(r);
    endfunction

    task automatic start_run(int n, int q, bit vld);
        start = 1'b1; rec_len = NW'(n); bin_idx = NW'(q);
        smp_valid = vld; exc_smp = 12'sd777; rsp_smp = -12'sd555;
        @(negedge clk);
        start = 1'b0; smp_valid = 1'b0;
    endtask

    task automatic feed(int n, int q, real ae, real pe, real ar, real pr,
                        int k0, int k1, bit gap);
        for (int k = k0; k < k1; k++) begin
            if (gap && (k % 3 == 1)) begin
                smp_valid = 1'b0; exc_smp = -12'sd1000; rsp_smp = 12'sd900;
                @(negedge clk);
            end
            smp_valid = 1'b1;
            exc_smp = samp(ae, pe, k, n, q);
            rsp_smp = samp(ar, pr, k, n, q);
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic run_full(int n, int q, real ae, real pe, real ar, real pr, bit gap);
        real sc;
        start_run(n, q, 1'b0);
        feed(n, q, ae, pe, ar, pr, 0, n, gap);
        chk("R6", "done at end", longint'(done), 1, 0);
        chk("R6", "busy at end", longint'(busy), 0, 0);
        @(negedge clk);
        chk("R6", "done one cycle", longint'(done), 0, 0);
        if (q > 0 && 2 * q < n) begin
            sc = 32767.0 * real'(n) / 2.0;
            chk_real("R7", "exc_re ideal", exc_re, ae * sc * $sin(pe * PI / 180.0), 0.02 * ae * sc);
            chk_real("R7", "exc_im ideal", exc_im, -ae * sc * $cos(pe * PI / 180.0), 0.02 * ae * sc);
            chk_real("R7", "rsp_re ideal", rsp_re, ar * sc * $sin(pr * PI / 180.0), 0.02 * ar * sc);
            chk_real("R7", "rsp_im ideal", rsp_im, -ar * sc * $cos(pr * PI / 180.0), 0.02 * ar * sc);
        end
    endtask

    initial begin : main
        longint s_er, s_ei, s_rr, s_ri;
        repeat (3) @(negedge clk);
        chk("R1", "busy after reset", longint'(busy), 0, 0);
        chk("R1", "done after reset", longint'(done), 0, 0);
        chk("R1", "exc_re after reset", exc_re, 0, 0);
        chk("R1", "rsp_im after reset", rsp_im, 0, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        // main function, continuous valid
        run_full(100, 7, 2000.0, 30.0, 1200.0, -45.0, 1'b0);

        // samples offered while idle must be dropped
        s_er = exc_re; s_ei = exc_im; s_rr = rsp_re; s_ri = rsp_im;
        for (int k = 0; k < 5; k++) begin
            smp_valid = 1'b1; exc_smp = SW'(300 * k - 900); rsp_smp = SW'(1500 - 200 * k);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        chk("R3", "idle exc_re", exc_re, s_er, 0);
        chk("R3", "idle exc_im", exc_im, s_ei, 0);
        chk("R3", "idle rsp_re", rsp_re, s_rr, 0);
        chk("R3", "idle rsp_im", rsp_im, s_ri, 0);
        chk("R3", "idle done", longint'(done), 0, 0);

        // non-power-of-two length with valid gaps
        run_full(401, 13, 1800.0, 120.0, 900.0, -150.0, 1'b1);

        // DC bin
        run_full(20, 0, 500.0, -90.0, 1500.0, 90.0, 1'b0);
        chk("R8", "dc exc_re", exc_re, -500 * 32767 * 20, 0);
        chk("R8", "dc exc_im", exc_im, 0, 0);
        chk("R8", "dc rsp_re", rsp_re, 1500 * 32767 * 20, 0);
        chk("R8", "dc rsp_im", rsp_im, 0, 0);

        // half-rate bin: sine reference zero, cosine alternates
        run_full(8, 4, 2047.0, 90.0, 1000.0, 90.0, 1'b0);
        chk("R4", "nyq exc_re", exc_re, 8 * 2047 * 32767, 0);
        chk("R4", "nyq exc_im", exc_im, 0, 0);
        chk("R4", "nyq rsp_re", rsp_re, 8 * 1000 * 32767, 0);
        chk("R4", "nyq rsp_im", rsp_im, 0, 0);

        // single-sample record
        run_full(1, 0, 700.0, 90.0, 300.0, -90.0, 1'b0);
        chk("R10", "n1 exc_re", exc_re, 700 * 32767, 0);
        chk("R10", "n1 rsp_re", rsp_re, -300 * 32767, 0);

        // restart mid-record with a valid pair alongside start
        start_run(50, 3, 1'b0);
        feed(50, 3, 1000.0, 10.0, 800.0, 70.0, 0, 10, 1'b0);
        chk("R2", "mid busy", longint'(busy), 1, 0);
        start_run(64, 5, 1'b1);
        chk("R2", "restart exc_re", exc_re, 0, 0);
        chk("R2", "restart exc_im", exc_im, 0, 0);
        chk("R2", "restart rsp_re", rsp_re, 0, 0);
        chk("R2", "restart busy", longint'(busy), 1, 0);
        feed(64, 5, 1500.0, -60.0, 600.0, 15.0, 0, 64, 1'b0);
        chk("R6", "restart done", longint'(done), 1, 0);
        @(negedge clk);

        // full-scale input on both channels
        run_full(300, 37, 2047.0, 10.0, 2047.0, 200.0, 1'b0);
        chk("R9", "fullscale exc_re sign", longint'(exc_re > 0), 1, 0);
        chk("R9", "fullscale rsp_re sign", longint'(rsp_re < 0), 1, 0);

        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule